// File: doc/BRIEF.md
# Serial EEPROM Page-Write Slave

This block is the receive side of a two-wire serial EEPROM. It follows the I2C clock and data lines and detects START and STOP. It checks the control byte and takes a word address into an 11-bit pointer. The top bits of that pointer come from the block-select field of the control byte. The block then collects one data byte, or a run of bytes, into a 16-entry page buffer. It acknowledges each byte it accepts by pulling the data line low during the ninth clock of that byte.

A STOP that follows at least one data byte starts an internal write cycle. This cycle lasts a fixed number of system clocks, set by a parameter. After it, the buffered bytes go out one per clock on a simple write port to a 2K-byte memory array that sits outside the block. While the cycle and the store-out run, the slave acknowledges nothing. This lets a bus master poll for completion.

The bus lines are sampled through two-stage synchronisers in the system clock domain. The open-drain data output appears as a single pull-low enable.

Top module: `eeprom_page_writer`

## Requirements
- R1: A control byte with 4'b1010 in bits 7:4 and 0 in bit 0 is acknowledged: `sda_oe` is high while SCL is high in the ninth clock of that byte. `sda_oe` changes only while SCL is low.
- R2: A control byte with a different device code, or with bit 0 set, is not acknowledged. Every further byte up to the next START is also not acknowledged, and nothing is written.
- R3: The pointer is {control bits 3:1, word-address byte}. The word-address byte is acknowledged, and the first data byte is stored at that 11-bit address.
- R4: Each data byte is acknowledged. After it, pointer bits 3:0 step by one modulo 16, and bits 10:4 stay constant, so a run that crosses the end of a page wraps to offset 0 of the same page.
- R5: When more than 16 data bytes arrive before STOP, a later byte replaces the earlier byte at the same page offset. Only the last value is stored, and each offset is written once.
- R6: No memory write happens before STOP. No memory write happens until the write-cycle time (WR_CYCLES clocks) has run after STOP.
- R7: While the write cycle runs, a valid control byte is not acknowledged, and the page buffer takes no bytes.
- R8: Once the write cycle and its store-out end, a valid control byte is acknowledged again.
- R9: A STOP before any data byte (after only a control byte or a word address) starts no write cycle and writes nothing. A control byte that follows at once is acknowledged.
- R10: During and just after reset, `sda_oe` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen on the pin |
| sda_in | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pull the data line low (acknowledge) |
| mem_we | output | 1 | Write strobe to the memory array |
| mem_addr | output | ADDR_W | Byte address for the memory write |
| mem_wdata | output | 8 | Byte to store |

## Verification
The hardest case to reach from the ports is a control byte that arrives inside the short window after STOP, before the write cycle has stored the page. The stimulus sends a repeated START and a control byte straight after the STOP of a page write. The write-cycle length is kept short in the bench, so the whole cycle fits between bus transactions and the recovery can be seen too. Page wrap and overwrite come from directed start offsets near the end of a page and runs longer than 16 bytes. The seeded random transactions vary block, offset and length around these cases.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

  typedef enum logic [2:0] {
    P_IDLE,
    P_CTRL,
    P_WADDR,
    P_DATA,
    P_SKIP
  } proto_st_t;

  typedef enum logic [1:0] {
    E_IDLE,
    E_WAIT,
    E_COMMIT
  } eng_st_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;

  // Control byte addresses this slave for a write.
  function automatic logic ctrl_is_write(input logic [7:0] b);
    return (b[7:4] == DEV_CODE) && !b[0];
  endfunction

  // Next in-page offset, wrapping at the page size 2**pw.
  function automatic int unsigned offs_step(input int unsigned offs, input int unsigned pw);
    return (offs + 1) % (1 << pw);
  endfunction

endpackage

// File: rtl/eepw_line_sync.sv
module eepw_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_m, scl_q, sda_m, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_m <= 1'b1; scl_s <= 1'b1; scl_q <= 1'b1;
      sda_m <= 1'b1; sda_s <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_m <= scl_in; scl_s <= scl_m; scl_q <= scl_s;
      sda_m <= sda_in; sda_s <= sda_m; sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eepw_proto.sv
module eepw_proto
  import eepw_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int PAGE_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_s,
  input  logic                     sda_s,
  input  logic                     scl_rise,
  input  logic                     scl_fall,
  input  logic                     start_ev,
  input  logic                     stop_ev,
  input  logic                     busy,
  output logic                     sda_oe,
  output logic                     buf_we,
  output logic                     buf_clr,
  output logic [PAGE_W-1:0]        buf_idx,
  output logic [7:0]               buf_data,
  output logic [ADDR_W-PAGE_W-1:0] page_base,
  output logic                     commit_req
);
  localparam int BLK_W = ADDR_W - 8;
  localparam int HI_W  = ADDR_W - PAGE_W;

  proto_st_t         st;
  logic [3:0]        bitcnt;
  logic              ack_ph;
  logic [7:0]        shreg;
  logic [BLK_W-1:0]  blk;
  logic [ADDR_W-1:0] ptr;
  logic              got_data;
  logic              rx_active;
  logic              byte_done;
  logic              ack_now;

  assign rx_active = (st == P_CTRL) || (st == P_WADDR) || (st == P_DATA);
  assign byte_done = rx_active && scl_fall && (bitcnt == 4'd8) && !ack_ph;

  always_comb begin
    unique case (st)
      P_CTRL:          ack_now = ctrl_is_write(shreg) && !busy;
      P_WADDR, P_DATA: ack_now = 1'b1;
      default:         ack_now = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= P_IDLE;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      shreg    <= '0;
      blk      <= '0;
      ptr      <= '0;
      got_data <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_ev) begin
      st       <= P_CTRL;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      sda_oe   <= 1'b0;
      got_data <= 1'b0;
    end else if (stop_ev) begin
      st       <= P_IDLE;
      bitcnt   <= '0;
      ack_ph   <= 1'b0;
      sda_oe   <= 1'b0;
      got_data <= 1'b0;
    end else begin
      if (scl_rise && rx_active && !ack_ph && (bitcnt < 4'd8)) begin
        shreg  <= {shreg[6:0], sda_s};
        bitcnt <= bitcnt + 4'd1;
      end
      if (scl_fall && ack_ph) begin
        ack_ph <= 1'b0;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end else if (byte_done) begin
        ack_ph <= 1'b1;
        sda_oe <= ack_now;
        unique case (st)
          P_CTRL: begin
            if (ack_now) begin
              blk <= shreg[BLK_W:1];
              st  <= P_WADDR;
            end else begin
              st  <= P_SKIP;
            end
          end
          P_WADDR: begin
            ptr <= {blk, shreg};
            st  <= P_DATA;
          end
          P_DATA: begin
            ptr      <= {ptr[ADDR_W-1:PAGE_W],
                         PAGE_W'(offs_step(int'(ptr[PAGE_W-1:0]), PAGE_W))};
            got_data <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign buf_we     = byte_done && (st == P_DATA);
  assign buf_clr    = byte_done && (st == P_WADDR);
  assign buf_idx    = ptr[PAGE_W-1:0];
  assign buf_data   = shreg;
  assign page_base  = ptr[ADDR_W-1:PAGE_W];
  assign commit_req = stop_ev && (st == P_DATA) && got_data;

  // R1
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R4
  page_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == P_DATA)) |=>
      (ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W])) &&
      (ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1)));

  // R7
  busy_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && (st == P_CTRL) && busy) |=> !sda_oe);

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = page_base;
endmodule

// File: rtl/eepw_wr_engine.sv
module eepw_wr_engine
  import eepw_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 5000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     buf_we,
  input  logic                     buf_clr,
  input  logic [PAGE_W-1:0]        buf_idx,
  input  logic [7:0]               buf_data,
  input  logic [ADDR_W-PAGE_W-1:0] page_base,
  input  logic                     commit_req,
  output logic                     busy,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [7:0]               mem_wdata
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - PAGE_W;
  localparam int TM_W   = $clog2(WR_CYCLES + 1);

  eng_st_t           st;
  logic [TM_W-1:0]   tmr;
  logic [PAGE_W-1:0] cidx;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_N-1:0] vld;
  logic [7:0]        pbuf [PAGE_N];

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[buf_idx] <= buf_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= E_IDLE;
      tmr    <= '0;
      cidx   <= '0;
      page_q <= '0;
      vld    <= '0;
    end else begin
      if (buf_clr) vld <= '0;
      if (buf_we)  vld[buf_idx] <= 1'b1;
      unique case (st)
        E_IDLE: if (commit_req) begin
          page_q <= page_base;
          tmr    <= '0;
          st     <= E_WAIT;
        end
        E_WAIT: if (tmr == TM_W'(WR_CYCLES - 1)) begin
          cidx <= '0;
          st   <= E_COMMIT;
        end else begin
          tmr <= tmr + 1'b1;
        end
        E_COMMIT: begin
          cidx <= cidx + 1'b1;
          if (cidx == PAGE_W'(PAGE_N - 1)) begin
            vld <= '0;
            st  <= E_IDLE;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  assign busy      = (st != E_IDLE);
  assign mem_we    = (st == E_COMMIT) && vld[cidx];
  assign mem_addr  = {page_q, cidx};
  assign mem_wdata = pbuf[cidx];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
  parameter int ADDR_W    = 11,
  parameter int PAGE_W    = 4,
  parameter int WR_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic busy, buf_we, buf_clr, commit_req;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0]        buf_data;
  logic [HI_W-1:0]   page_base;

  eepw_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eepw_proto #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .busy(busy), .sda_oe(sda_oe), .buf_we(buf_we),
    .buf_clr(buf_clr), .buf_idx(buf_idx), .buf_data(buf_data),
    .page_base(page_base), .commit_req(commit_req)
  );

  eepw_wr_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_eng (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_clr(buf_clr),
    .buf_idx(buf_idx), .buf_data(buf_data), .page_base(page_base),
    .commit_req(commit_req), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  // R9
  stop_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !busy && !commit_req) |=> !busy);

  // R7
  buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> !busy);

  // R6
  commit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_req |=> (busy && !mem_we));
endmodule

// File: tb/sim_eeprom_page_writer.sv
`timescale 1ns/1ps
module sim_eeprom_page_writer;
  localparam int WRC = 300;
  localparam int H   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic sda_oe, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic sda_bus;

  assign sda_bus = msda & ~sda_oe;
  always #2.5 clk = ~clk;

  eeprom_page_writer #(.ADDR_W(11), .PAGE_W(4), .WR_CYCLES(WRC)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
    .sda_oe(sda_oe), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  logic [7:0] mem [0:2047];
  int wcount = 0;
  always @(posedge clk) if (mem_we) begin
    mem[mem_addr] <= mem_wdata;
    wcount <= wcount + 1;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int pos_of(input int base_lo, input int k);
    return (base_lo + k) % 16;
  endfunction

  task automatic i_start();
    msda = 1'b1; wt(H/2); scl = 1'b1; wt(H); msda = 1'b0; wt(H); scl = 1'b0; wt(H/2);
  endtask

  task automatic i_stop();
    msda = 1'b0; wt(H/2); scl = 1'b1; wt(H); msda = 1'b1; wt(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      msda = b[i]; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
    end
    msda = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
    ack = sda_oe;
    wt(H/2); scl = 1'b0; wt(H/2);
  endtask

  logic [7:0] txd [0:39];

  // Full write transaction with model check; probe=1 pokes the busy window.
  task automatic do_write(input int blk, input int waddr, input int n, input bit probe);
    bit ack;
    bit ev [16];
    logic [7:0] ed [16];
    int w0, nv;
    logic [10:0] base;
    base = {blk[2:0], waddr[7:0]};
    for (int p = 0; p < 16; p++) ev[p] = 0;
    w0 = wcount;
    i_start();
    send_byte({4'b1010, blk[2:0], 1'b0}, ack); chk("R1 ctrl ack", ack, 1);
    send_byte(waddr[7:0], ack);                chk("R3 waddr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      send_byte(txd[k], ack);
      chk("R4 data ack", ack, 1);
      ev[pos_of(waddr % 16, k)] = 1;
      ed[pos_of(waddr % 16, k)] = txd[k];
    end
    chk("R6 no write before stop", wcount - w0, 0);
    i_stop();
    wt(5);
    chk("R6 no write right after stop", wcount - w0, 0);
    if (probe) begin
      i_start();
      send_byte(8'hA0, ack); chk("R7 nack while busy", ack, 0);
      i_stop();
      chk("R6 no write during cycle", wcount - w0, 0);
    end
    wt(WRC + 40);
    nv = 0;
    for (int p = 0; p < 16; p++) if (ev[p]) begin
      nv++;
      chk("R3/R4/R5 stored byte", mem[{base[10:4], p[3:0]}], ed[p]);
    end
    chk("R5 write count", wcount - w0, nv);
  endtask

  initial begin
    bit ack;
    int w0;
    void'($urandom(32'd1234));
    wt(3);
    chk("R10 sda_oe in reset", sda_oe, 0);
    chk("R10 mem_we in reset", mem_we, 0);
    rst_n = 1'b1;
    wt(4);
    chk("R10 sda_oe after reset", sda_oe, 0);
    chk("R10 mem_we after reset", mem_we, 0);

    // single byte write, R1 R3
    txd[0] = 8'h5A;
    do_write(5, 8'h3C, 1, 0);

    // page wrap across offset 15, R4
    for (int k = 0; k < 4; k++) txd[k] = 8'h10 + k[7:0];
    do_write(2, 8'h9E, 4, 0);

    // overflow beyond 16 bytes, R5
    for (int k = 0; k < 20; k++) txd[k] = 8'hC0 + k[7:0];
    do_write(7, 8'h23, 20, 0);

    // busy window, R7 R8
    for (int k = 0; k < 3; k++) txd[k] = 8'h71 + k[7:0];
    do_write(1, 8'h40, 3, 1);

    // R8 acknowledge resumes; R9 stop without data
    w0 = wcount;
    i_start();
    send_byte(8'hA6, ack); chk("R8 ack after cycle", ack, 1);
    send_byte(8'h11, ack); chk("R9 waddr ack", ack, 1);
    i_stop();
    i_start();
    send_byte(8'hA6, ack); chk("R9 ctrl ack, no cycle started", ack, 1);
    i_stop();
    wt(WRC + 40);
    chk("R9 no writes", wcount - w0, 0);

    // wrong device code and read bit, R2
    w0 = wcount;
    i_start();
    send_byte(8'hB0, ack); chk("R2 bad code nack", ack, 0);
    send_byte(8'h10, ack); chk("R2 following byte nack", ack, 0);
    send_byte(8'h33, ack); chk("R2 third byte nack", ack, 0);
    i_stop();
    i_start();
    send_byte(8'hA1, ack); chk("R2 read bit nack", ack, 0);
    i_stop();
    wt(WRC + 40);
    chk("R2 no writes", wcount - w0, 0);

    // seeded random transactions
    for (int t = 0; t < 6; t++) begin
      int nb, blk, wa;
      nb  = int'($urandom_range(1, 22));
      blk = int'($urandom_range(0, 7));
      wa  = int'($urandom_range(0, 255));
      for (int k = 0; k < nb; k++) txd[k] = 8'($urandom_range(0, 255));
      do_write(blk, wa, nb, 0);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule